// File: doc/BRIEF.md
# Link Delay Statistics Calculator

This block condenses a set of raw link-latency readings into the two settings that align several links to a common multiframe boundary. The readings are gathered with the alignment delay programmed to zero, across many power cycles, links and devices. Each reading is a count of PCLK cycles, taken modulo the multiframe length. When a spread of readings crosses the multiframe edge, some of them come back as small values that really belong just past the edge. The block detects that case, adds one multiframe length to the affected readings, and then finds the true minimum and maximum.

Readings arrive one per `smp_vld` strobe while the block is in its collect state. They go into an internal buffer of `DEPTH` entries. A `fin` strobe starts a scan of fixed length over the buffer. The scan unwraps each stored reading, tracks the extremes, and publishes four values. The first is the minimum and the second is the maximum. The third is the variation setting, one cycle of guard band added on each side of the range. The fourth is the delay setting, which is the minimum less one cycle of guard band, reduced modulo the multiframe length. `done` then rises and the results hold until `clr`.

The controller has four states. S_IDLE collects readings, S_SCAN walks the buffer, S_CALC forms the settings, and S_DONE holds them. Transition T_FIN goes from S_IDLE to S_SCAN on `fin`. T_LAST goes from S_SCAN to S_CALC after the last buffer index. T_PUBLISH goes from S_CALC to S_DONE unconditionally. T_CLR returns any state to S_IDLE when `clr` is high.

Top module: `ldc_stats_top`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `done`, `min_o`, `max_o`, `var_o` and `dly_set` are all zero. `clr` overrides every state and discards all stored readings.
- R2: In S_IDLE, every cycle with `smp_vld` high stores `smp_raw`. Only the first `DEPTH` (default 64) readings after a clear are kept; later readings have no effect on the results.
- R3: Wrap correction is applied only when at least one kept reading is below `mf_len/4` (floor) and at least one is at or above `mf_len - mf_len/4`. When it is applied, each reading below `mf_len/2` (floor) has `mf_len` added before comparison. Readings must be less than `mf_len`.
- R4: `min_o` and `max_o` are the smallest and largest corrected readings among all kept readings, and `max_o >= min_o`.
- R5: `var_o` equals `(max_o + 1) - (min_o - 1)`. For example, corrected readings spanning 4 to 9 give 7.
- R6: `dly_set` equals `(min_o - 1)` modulo `mf_len`. When `min_o` is 0 the result is `mf_len - 1`. With `min_o` = 4 and `mf_len` = 8 it is 3.
- R7: `done` rises exactly `DEPTH + 1` clock edges after the edge that samples `fin` in S_IDLE. A reading presented in the same cycle as `fin` is included.
- R8: Once `done` is high, it and all results hold until `clr`. `smp_vld` and `fin` are ignored outside S_IDLE.
- R9: If `fin` arrives with no kept readings, `done` still rises on schedule and all four results are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear: drop readings, zero results, return to collect |
| smp_vld | input | 1 | Raw reading valid strobe |
| smp_raw | input | RAW_W | Raw latency reading, in PCLK cycles, modulo multiframe |
| fin | input | 1 | Start computation over the collected readings |
| mf_len | input | RAW_W | Multiframe length in PCLK cycles (at least 4), held stable |
| min_o | output | RAW_W+1 | Smallest corrected reading |
| max_o | output | RAW_W+1 | Largest corrected reading |
| var_o | output | RAW_W+2 | Guard-banded delay variation setting |
| dly_set | output | RAW_W | Guard-banded delay setting, modulo multiframe |
| done | output | 1 | Results valid and held |

## Verification
Two situations are hard to reach from the ports. The first is a reading that lands after the buffer is already full. Reaching it takes a long stream of identical mid-range readings followed by low readings that would drag the minimum down if they were kept. The second is a reading arriving in the same cycle as `fin`. It is driven together with the strobe, and its value is chosen below every earlier reading, so that its inclusion is visible in `min_o`. The wrap decision is approached from both sides. One case has readings in both outer quarters. Another has a low reading with no high one, which must not be corrected. A third case repeats the correction with a different multiframe length.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_CALC = 2'd2,
        S_DONE = 2'd3
    } ldc_state_e;
endpackage

// File: rtl/ldc_sample_buf.sv
module ldc_sample_buf #(
    parameter int RAW_W = 8,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [RAW_W-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [RAW_W-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             full
);
    logic [RAW_W-1:0] mem [DEPTH];

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr_en && !full) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clr) begin
            mem[count[IW-1:0]] <= wr_data;
        end
    end
endmodule

// File: rtl/ldc_range_class.sv
module ldc_range_class #(
    parameter int RAW_W = 8,
    localparam int UW = RAW_W + 1
) (
    input  logic [RAW_W-1:0] raw,
    input  logic [RAW_W-1:0] mf,
    input  logic             wrap,
    output logic             is_lo,
    output logic             is_hi,
    output logic [UW-1:0]    unw
);
    logic [RAW_W-1:0] quarter;
    logic [RAW_W-1:0] half;

    always_comb begin
        quarter = mf >> 2;
        half    = mf >> 1;
        is_lo   = (raw < quarter);
        is_hi   = (raw >= (mf - quarter));
        if (wrap && (raw < half)) begin
            unw = UW'(raw) + UW'(mf);
        end else begin
            unw = UW'(raw);
        end
    end
endmodule

// File: rtl/ldc_extrema.sv
module ldc_extrema #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         upd,
    input  logic [W-1:0] val,
    output logic [W-1:0] mn,
    output logic [W-1:0] mx,
    output logic         seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mn   <= '1;
            mx   <= '0;
            seen <= 1'b0;
        end else if (init) begin
            mn   <= '1;
            mx   <= '0;
            seen <= 1'b0;
        end else if (upd) begin
            seen <= 1'b1;
            if (val < mn) mn <= val;
            if (val > mx) mx <= val;
        end
    end
endmodule

// File: rtl/ldc_stats_top.sv
module ldc_stats_top
    import ldc_pkg::*;
#(
    parameter int RAW_W = 8,
    parameter int DEPTH = 64,
    localparam int UW = RAW_W + 1,
    localparam int VW = RAW_W + 2,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp_vld,
    input  logic [RAW_W-1:0] smp_raw,
    input  logic             fin,
    input  logic [RAW_W-1:0] mf_len,
    output logic [UW-1:0]    min_o,
    output logic [UW-1:0]    max_o,
    output logic [VW-1:0]    var_o,
    output logic [RAW_W-1:0] dly_set,
    output logic             done
);
    ldc_state_e st, nxt;
    logic [IW-1:0]    idx;
    logic             lo_seen, hi_seen, wrap;
    logic             wr_en, full;
    logic [CW-1:0]    count;
    logic [RAW_W-1:0] rd_data;
    logic             w_lo, w_hi, r_lo, r_hi;
    logic [UW-1:0]    w_unw, r_unw;
    logic             ext_init, ext_upd, seen;
    logic [UW-1:0]    mn, mx;

    assign wr_en    = smp_vld && (st == S_IDLE) && !clr;
    assign wrap     = lo_seen && hi_seen;
    assign ext_init = clr || ((st == S_IDLE) && fin);
    assign ext_upd  = (st == S_SCAN) && (CW'(idx) < count);
    assign done     = (st == S_DONE);

    ldc_sample_buf #(.RAW_W(RAW_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
        .wr_data(smp_raw), .rd_idx(idx), .rd_data(rd_data),
        .count(count), .full(full)
    );

    // Classifier on the write side feeds the wrap flags.
    ldc_range_class #(.RAW_W(RAW_W)) u_cls_wr (
        .raw(smp_raw), .mf(mf_len), .wrap(1'b0),
        .is_lo(w_lo), .is_hi(w_hi), .unw(w_unw)
    );

    // Classifier on the read side applies the wrap decision.
    ldc_range_class #(.RAW_W(RAW_W)) u_cls_rd (
        .raw(rd_data), .mf(mf_len), .wrap(wrap),
        .is_lo(r_lo), .is_hi(r_hi), .unw(r_unw)
    );

    ldc_extrema #(.W(UW)) u_ext (
        .clk(clk), .rst_n(rst_n), .init(ext_init), .upd(ext_upd),
        .val(r_unw), .mn(mn), .mx(mx), .seen(seen)
    );

    // Next state: T_FIN, T_LAST, T_PUBLISH, T_CLR
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: if (fin) nxt = S_SCAN;
            S_SCAN: if (idx == IW'(DEPTH - 1)) nxt = S_CALC;
            S_CALC: nxt = S_DONE;
            S_DONE: nxt = S_DONE;
        endcase
        if (clr) nxt = S_IDLE;
    end

    // State register and scan index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            idx <= '0;
        end else begin
            st  <= nxt;
            idx <= (st == S_SCAN && nxt == S_SCAN) ? idx + IW'(1) : '0;
        end
    end

    // Outputs and collect-side flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
            min_o   <= '0;
            max_o   <= '0;
            var_o   <= '0;
            dly_set <= '0;
        end else if (clr) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
            min_o   <= '0;
            max_o   <= '0;
            var_o   <= '0;
            dly_set <= '0;
        end else begin
            if (wr_en && !full) begin
                lo_seen <= lo_seen | w_lo;
                hi_seen <= hi_seen | w_hi;
            end
            if (st == S_CALC && seen) begin
                min_o   <= mn;
                max_o   <= mx;
                var_o   <= VW'(mx) - VW'(mn) + VW'(2);
                dly_set <= (mn == '0) ? (mf_len - RAW_W'(1))
                                      : RAW_W'(mn - UW'(1));
            end
        end
    end

    logic unused_ok;
    assign unused_ok = ^{r_lo, r_hi, w_unw};
endmodule

// File: rtl/ldc_stats_chk.sv
module ldc_stats_chk #(
    parameter int RAW_W = 8,
    localparam int UW = RAW_W + 1,
    localparam int VW = RAW_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [RAW_W-1:0] mf_len,
    input logic [UW-1:0]    min_o,
    input logic [UW-1:0]    max_o,
    input logic [VW-1:0]    var_o,
    input logic [RAW_W-1:0] dly_set,
    input logic             done
);
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && min_o == '0 && max_o == '0 && var_o == '0 && dly_set == '0));

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (max_o >= min_o));

    p_var_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && var_o != '0) |-> (var_o == VW'(max_o) - VW'(min_o) + VW'(2)));

    p_dly_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && min_o != '0) |-> (dly_set == RAW_W'(min_o - UW'(1))));

    p_dly_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && var_o != '0 && min_o == '0) |-> (dly_set == mf_len - RAW_W'(1)));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

    p_out_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> ($stable(min_o) && $stable(max_o) && $stable(var_o) && $stable(dly_set)));

    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && var_o == '0) |-> (min_o == '0 && max_o == '0 && dly_set == '0));
endmodule

bind ldc_stats_top ldc_stats_chk #(.RAW_W(RAW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mf_len(mf_len),
    .min_o(min_o), .max_o(max_o), .var_o(var_o), .dly_set(dly_set), .done(done)
);

// File: tb/sim_ldc_stats_top.sv
`timescale 1ns/1ps
module sim_ldc_stats_top;
    localparam int RAW_W = 8;
    localparam int DEPTH = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             smp_vld = 1'b0;
    logic [RAW_W-1:0] smp_raw = '0;
    logic             fin = 1'b0;
    logic [RAW_W-1:0] mf_len = 8'd8;
    logic [RAW_W:0]   min_o, max_o;
    logic [RAW_W+1:0] var_o;
    logic [RAW_W-1:0] dly_set;
    logic             done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldc_stats_top #(.RAW_W(RAW_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .smp_raw(smp_raw), .fin(fin), .mf_len(mf_len),
        .min_o(min_o), .max_o(max_o), .var_o(var_o),
        .dly_set(dly_set), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic put(input int v);
        @(negedge clk); smp_vld = 1'b1; smp_raw = RAW_W'(v);
        @(negedge clk); smp_vld = 1'b0;
    endtask

    // Pulse fin, verify R7 timing, leave at a negedge with done high.
    task automatic finish_run();
        @(negedge clk); fin = 1'b1;
        @(negedge clk); fin = 1'b0;
        repeat (DEPTH) @(negedge clk);
        chk("R7 done low one cycle early", int'(done), 0);
        @(negedge clk);
        chk("R7 done on schedule", int'(done), 1);
    endtask

    task automatic expect_res(input string req, input int mn, input int mx,
                              input int vr, input int dl);
        chk({req, " min"}, int'(min_o), mn);
        chk({req, " max"}, int'(max_o), mx);
        chk({req, " var"}, int'(var_o), vr);
        chk({req, " dly"}, int'(dly_set), dl);
    endtask

    task automatic t_reset();
        chk("R1 reset done", int'(done), 0);
        expect_res("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_wrap_example();
        do_clear(); mf_len = 8'd8;
        put(6); put(7); put(0); put(1); put(5); put(7); put(4); put(6);
        finish_run();
        expect_res("R3 R5 R6 wrap example", 4, 9, 7, 3);
    endtask

    task automatic t_no_wrap();
        do_clear(); mf_len = 8'd8;
        put(3); put(2); put(5);
        finish_run();
        expect_res("R4 plain range", 2, 5, 5, 1);
    endtask

    task automatic t_low_only();
        do_clear(); mf_len = 8'd8;
        put(0); put(3); put(1);
        finish_run();
        expect_res("R3 low only no wrap, R6 negative", 0, 3, 5, 7);
    endtask

    task automatic t_mf16();
        do_clear(); mf_len = 8'd16;
        put(14); put(1); put(15); put(2);
        finish_run();
        expect_res("R3 mf16 wrap", 14, 18, 6, 13);
    endtask

    task automatic t_overflow();
        do_clear(); mf_len = 8'd8;
        for (int i = 0; i < DEPTH; i++) put(5);
        for (int i = 0; i < 6; i++) put(1);
        finish_run();
        expect_res("R2 overflow dropped", 5, 5, 2, 4);
    endtask

    task automatic t_empty();
        do_clear();
        finish_run();
        expect_res("R9 empty", 0, 0, 0, 0);
    endtask

    task automatic t_fin_with_sample();
        do_clear(); mf_len = 8'd8;
        put(5); put(6);
        @(negedge clk); smp_vld = 1'b1; smp_raw = 8'd3; fin = 1'b1;
        @(negedge clk); smp_vld = 1'b0; fin = 1'b0;
        repeat (DEPTH + 1) @(negedge clk);
        chk("R7 done with joint sample", int'(done), 1);
        expect_res("R7 joint sample included", 3, 6, 5, 2);
    endtask

    task automatic t_hold_and_clear();
        do_clear(); mf_len = 8'd8;
        put(4); put(6);
        finish_run();
        put(0); put(7);
        @(negedge clk); fin = 1'b1;
        @(negedge clk); fin = 1'b0;
        repeat (DEPTH + 4) @(negedge clk);
        chk("R8 done held", int'(done), 1);
        expect_res("R8 held results", 4, 6, 4, 3);
        do_clear();
        chk("R1 clear done", int'(done), 0);
        expect_res("R1 clear", 0, 0, 0, 0);
    endtask

    task automatic t_clear_discards();
        do_clear(); mf_len = 8'd8;
        put(1); put(2);
        do_clear();
        put(5); put(6);
        finish_run();
        expect_res("R1 clear discards readings", 5, 6, 3, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap_example();
        t_no_wrap();
        t_low_only();
        t_mf16();
        t_overflow();
        t_empty();
        t_fin_with_sample();
        t_hold_and_clear();
        t_clear_discards();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule